// File: doc/BRIEF.md
# Clock Mode Control Register

This block holds the 8-bit clock mode register of a small processor. Software writes it through a one-byte bus port. The register chooses whether the CPU clock comes from the internal ring oscillator or from an external oscillator. It also records whether that external part is ceramic or RC, selects the division ratio, and switches each oscillator on or off. From the stored value the block produces registered control outputs for the clock tree and a read-back byte.

Three bits are protected against runaway code: bit 5 (oscillator type) and bits 1:0 (mode field). They accept one write after reset and then freeze until the next reset. A bit-set or bit-clear operation on any other bit also freezes them. The bus marks such operations with a flag, and the write data then carries the whole byte with only the target bit changed.

A write that would leave the CPU without a running clock is rejected as a whole. A double-speed request is only honoured when a ceramic oscillator drives the CPU. Returning from the external oscillator to the ring oscillator always lands in ring divide-by-8.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the read byte is 0x48. This means division field 01 (divide-by-8), type bit 0, external enable 0, ring enable 1, source bit 0 (ring) and mode bits 00. The source output is 00 (ring), the lock flag is 0, the double-speed permit is 0, the external enable output is 0 and the ring enable output is 1.
- R2: While the lock flag is clear, a plain write loads bits 5, 1 and 0 from the data. Every write of any kind sets the lock flag. While the flag is set, bits 5, 1 and 0 keep their value whatever is written, until reset clears the flag.
- R3: A bit-set or bit-clear write (rmw flag high) whose data differs from the stored byte in any of bits 7:6 or 4:2 leaves bits 5, 1 and 0 unchanged and sets the lock flag. If it differs only in bits 5, 1 or 0 and the lock flag is clear, those bits are loaded.
- R4: Bit 2 selects the CPU clock source (0 ring, 1 external) and bit 5 the external type (1 ceramic, 0 RC). The source output reads 00 for ring, 01 for ceramic and 10 for RC.
- R5: A write is rejected as a whole, leaving the stored byte unchanged, if the new value disables the oscillator of the currently selected source or the oscillator of the newly selected source. Bit 4 enables the external oscillator and bit 3 the ring oscillator.
- R6: Division field bits 7:6 encode 00 = divide-by-2, 01 = divide-by-8, 10 = divide-by-4, 11 = divide-by-1 (double speed). The value 11 is stored only if the new value selects an external ceramic source. Otherwise the field keeps its previous value. The double-speed permit output is 1 exactly when the source is external ceramic.
- R7: An accepted write that changes bit 2 from 1 to 0 stores division field 01, whatever the data holds.
- R8: The read byte equals the stored register. The external enable output equals bit 4, the ring enable output equals bit 3 and the division output equals bits 7:6. All outputs change on the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| rmw_i | input | 1 | Marks the write as a single-bit set or clear operation |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register value |
| clk_src_o | output | 2 | CPU clock source: 00 ring, 01 ceramic, 10 RC |
| div_sel_o | output | 2 | Division ratio field |
| xin_en_o | output | 1 | External oscillator enable |
| ring_en_o | output | 1 | Ring oscillator enable |
| dbl_ok_o | output | 1 | Double-speed division permitted |
| locked_o | output | 1 | Sticky lock flag for bits 5, 1 and 0 |

## Verification
The assertions assume two things. First, each write strobe lasts one cycle with stable data. Second, an rmw write carries the stored byte with a single bit flipped, as the bus produces for bit operations. The random phase builds every rmw write from the model's current byte with one bit inverted, while plain writes use arbitrary data. Resets are scattered between writes, so the write-once window is exercised many times.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] CRIT_MASK = 8'b0010_0011;
  localparam int unsigned DIV_HI = 7;
  localparam int unsigned DIV_LO = 6;
  localparam int unsigned TYPE_B = 5;
  localparam int unsigned XEN_B  = 4;
  localparam int unsigned REN_B  = 3;
  localparam int unsigned SRC_B  = 2;

  typedef enum logic [1:0] {
    SRC_RING    = 2'b00,
    SRC_CERAMIC = 2'b01,
    SRC_RC      = 2'b10
  } clk_src_e;

  typedef enum logic [1:0] {
    DIV_2 = 2'b00,
    DIV_8 = 2'b01,
    DIV_4 = 2'b10,
    DIV_1 = 2'b11
  } div_e;
endpackage

// File: rtl/clkmode_lock.sv
module clkmode_lock
  import clkmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rmw,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] cur,
  output logic             locked,
  output logic [REG_W-1:0] merged
);
  logic locked_q;
  logic other_diff;
  logic take_crit;

  always_comb begin
    other_diff = |((wdata ^ cur) & ~CRIT_MASK);
    take_crit  = !locked_q && !(rmw && other_diff);
    merged     = take_crit ? wdata : ((wdata & ~CRIT_MASK) | (cur & CRIT_MASK));
  end

  always_ff @(posedge clk) begin
    if (rst)        locked_q <= 1'b0;
    else if (wr_en) locked_q <= 1'b1;
  end

  assign locked = locked_q;

  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);

  assert_write_locks_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> locked_q);
endmodule

// File: rtl/clkmode_check.sv
module clkmode_check
  import clkmode_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic [REG_W-1:0] cand,
  output logic             accept,
  output logic [REG_W-1:0] nxt
);
  logic       cur_ext;
  logic       new_ext;
  logic       cur_osc_kept;
  logic       new_osc_on;
  logic       dbl_legal;
  logic [1:0] div_n;

  always_comb begin
    cur_ext      = cur[SRC_B];
    new_ext      = cand[SRC_B];
    cur_osc_kept = cur_ext ? cand[XEN_B] : cand[REN_B];
    new_osc_on   = new_ext ? cand[XEN_B] : cand[REN_B];
    accept       = cur_osc_kept && new_osc_on;
    dbl_legal    = new_ext && cand[TYPE_B];
    if (cur_ext && !new_ext)
      div_n = DIV_8;
    else if ((cand[DIV_HI:DIV_LO] == DIV_1) && !dbl_legal)
      div_n = cur[DIV_HI:DIV_LO];
    else
      div_n = cand[DIV_HI:DIV_LO];
    nxt = accept ? {div_n, cand[DIV_LO-1:0]} : cur;
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 8'h48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             rmw_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [1:0]       clk_src_o,
  output logic [1:0]       div_sel_o,
  output logic             xin_en_o,
  output logic             ring_en_o,
  output logic             dbl_ok_o,
  output logic             locked_o
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] nxt;
  logic [REG_W-1:0] reg_d;
  logic             accept;
  logic [1:0]       src_d;

  clkmode_lock u_lock (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en_i),
    .rmw    (rmw_i),
    .wdata  (wdata_i),
    .cur    (reg_q),
    .locked (locked_o),
    .merged (merged)
  );

  clkmode_check u_check (
    .cur    (reg_q),
    .cand   (merged),
    .accept (accept),
    .nxt    (nxt)
  );

  always_comb begin
    reg_d = (wr_en_i && accept) ? nxt : reg_q;
    if (!reg_d[SRC_B])      src_d = SRC_RING;
    else if (reg_d[TYPE_B]) src_d = SRC_CERAMIC;
    else                    src_d = SRC_RC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= RST_VAL;
      rdata_o   <= RST_VAL;
      clk_src_o <= SRC_RING;
      div_sel_o <= RST_VAL[DIV_HI:DIV_LO];
      xin_en_o  <= RST_VAL[XEN_B];
      ring_en_o <= RST_VAL[REN_B];
      dbl_ok_o  <= 1'b0;
    end else begin
      reg_q     <= reg_d;
      rdata_o   <= reg_d;
      clk_src_o <= src_d;
      div_sel_o <= reg_d[DIV_HI:DIV_LO];
      xin_en_o  <= reg_d[XEN_B];
      ring_en_o <= reg_d[REN_B];
      dbl_ok_o  <= (src_d == SRC_CERAMIC);
    end
  end

  assert_crit_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(reg_q & CRIT_MASK));

  assert_src_alive_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_q[SRC_B] ? reg_q[XEN_B] : reg_q[REN_B]));

  assert_dbl_ceramic_R6: assert property (@(posedge clk) disable iff (rst)
    (div_sel_o == DIV_1) |-> (clk_src_o == SRC_CERAMIC));

  assert_ring_div8_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_q[SRC_B]) |-> (div_sel_o == DIV_8));

  assert_permit_match_R8: assert property (@(posedge clk) disable iff (rst)
    dbl_ok_o == (clk_src_o == SRC_CERAMIC));
endmodule

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en_i = 1'b0;
  logic       rmw_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [1:0] clk_src_o;
  logic [1:0] div_sel_o;
  logic       xin_en_o, ring_en_o, dbl_ok_o, locked_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_reg = 8'h48;
  logic       m_lk = 1'b0;
  logic       cmp_en = 1'b0;

  always #5 clk = ~clk;

  clkmode_ctrl dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rmw_i(rmw_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .clk_src_o(clk_src_o), .div_sel_o(div_sel_o),
    .xin_en_o(xin_en_o), .ring_en_o(ring_en_o), .dbl_ok_o(dbl_ok_o),
    .locked_o(locked_o)
  );

  function automatic logic [7:0] model_write(input logic [7:0] cur, input logic lk,
                                             input logic [7:0] wd, input logic bitop);
    logic [7:0] c;
    int osc_now, osc_new;
    c = wd;
    if (lk || (bitop && ((wd ^ cur) & 8'hDC) != 8'h00)) begin
      c[5] = cur[5]; c[1] = cur[1]; c[0] = cur[0];
    end
    osc_now = cur[2] ? 4 : 3;
    osc_new = c[2] ? 4 : 3;
    if (!c[osc_now] || !c[osc_new]) return cur;
    if (cur[2] && !c[2]) c[7:6] = 2'b01;
    else if (c[7:6] == 2'b11 && !(c[2] && c[5])) c[7:6] = cur[7:6];
    return c;
  endfunction

  function automatic logic [1:0] model_src(input logic [7:0] r);
    if (!r[2]) return 2'd0;
    return r[5] ? 2'd1 : 2'd2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= 8'h48;
      m_lk  <= 1'b0;
    end else if (wr_en_i) begin
      m_reg <= model_write(m_reg, m_lk, wdata_i, rmw_i);
      m_lk  <= 1'b1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check("R8 rdata vs model", rdata_o, m_reg);
      check("R4 source vs model", clk_src_o, model_src(m_reg));
      check("R7 div vs model", div_sel_o, m_reg[7:6]);
      check("R8 xin_en vs model", xin_en_o, m_reg[4]);
      check("R8 ring_en vs model", ring_en_o, m_reg[3]);
      check("R6 dbl_ok vs model", dbl_ok_o, model_src(m_reg) == 2'd1);
      check("R2 lock vs model", locked_o, m_lk);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, input logic bitop);
    @(negedge clk);
    wr_en_i = 1'b1; wdata_i = d; rmw_i = bitop;
    @(negedge clk);
    wr_en_i = 1'b0; rmw_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    cmp_en = 1'b1;
    check("R1 reset rdata", rdata_o, 8'h48);
    check("R1 reset source", clk_src_o, 0);
    check("R1 reset lock", locked_o, 0);
    check("R1 reset ring_en", ring_en_o, 1);
    check("R1 reset xin_en", xin_en_o, 0);
    check("R1 reset dbl_ok", dbl_ok_o, 0);

    do_write(8'h58, 1'b1);
    check("R3 bitop on other bit", rdata_o, 8'h58);
    check("R3 bitop locks", locked_o, 1);
    do_write(8'h7B, 1'b0);
    check("R2 crit bits frozen", rdata_o, 8'h58);

    do_reset();
    check("R1 reset clears lock", locked_o, 0);
    do_write(8'h7B, 1'b0);
    check("R2 first write loads", rdata_o, 8'h7B);
    do_write(8'h5B, 1'b0);
    check("R2 second write ignored", rdata_o, 8'h7B);
    do_write(8'h7F, 1'b0);
    check("R4 ceramic source", clk_src_o, 1);
    do_write(8'hFF, 1'b0);
    check("R6 double speed ceramic", div_sel_o, 3);
    check("R6 permit ceramic", dbl_ok_o, 1);
    do_write(8'hF7, 1'b0);
    check("R5 stop idle ring", rdata_o, 8'hF7);
    do_write(8'hE7, 1'b0);
    check("R5 stop running xin", rdata_o, 8'hF7);
    do_write(8'hF3, 1'b0);
    check("R5 switch to stopped ring", rdata_o, 8'hF7);
    do_write(8'hFB, 1'b0);
    check("R7 forced ring div8", rdata_o, 8'h7B);
    check("R7 source ring", clk_src_o, 0);

    do_reset();
    do_write(8'h1F, 1'b0);
    check("R4 RC source", clk_src_o, 2);
    do_write(8'hDF, 1'b0);
    check("R6 double speed RC blocked", rdata_o, 8'h1F);
    check("R6 permit RC", dbl_ok_o, 0);

    do_reset();
    do_write(8'hC8, 1'b0);
    check("R6 double speed ring blocked", rdata_o, 8'h48);

    do_reset();
    do_write(8'h68, 1'b1);
    check("R3 bitop on crit bit loads", rdata_o, 8'h68);
    do_write(8'h69, 1'b1);
    check("R3 bitop after lock ignored", rdata_o, 8'h68);

    for (int i = 0; i < 600; i++) begin
      if (($urandom % 40) == 0) do_reset();
      if ($urandom % 2) do_write(m_reg ^ (8'h01 << ($urandom % 8)), 1'b1);
      else              do_write(8'($urandom), 1'b0);
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule